// File: doc/BRIEF.md
# Hashed Page Table Walker

This block resolves a page translation that missed in the page TLB. It searches a hashed page table that lives in memory. A request carries a 24-bit virtual segment ID, a 16-bit page index, and the current value of the 32-bit storage-description register. From these the walker derives a hash and a 64-byte group address. It then reads the group's eight page table entries one after another, each as two 32-bit words, over a single-outstanding memory read port.

If no entry in the primary group qualifies, the walker runs a second pass. That pass uses the group selected by the bitwise complement of the hash. When an entry qualifies, the walker pulses `done` and returns the real page number, the protection bits, and the segment ID and page index that the TLB refill needs. If both passes come up empty, it pulses `fault` to signal a hash-table miss. The walker leaves the reference and change bits untouched.

Top module: `pte_walker`

## Requirements
- R1: After reset, `done`, `fault` and `rd_valid` are low and `req_ready` is high.
- R2: The hash is the low 19 bits of the segment ID XORed with the zero-extended page index. The group address is the origin OR (hash shifted left by 6, ANDed with the mask). The origin is `sdr[31:16]` placed in address bits 31:16. The mask is `sdr[8:0]` placed in bits 24:16, together with ones in bits 15:6.
- R3: The eight entries of a group are read in ascending order at group+8*i. Word 0 is at +0 and word 1 at +4, and word 0 is read first.
- R4: An entry qualifies only if all of these hold:
  - word 0 bit 31 (valid) is 1;
  - word 0 bit 6 (hash select) equals the pass number (0 for primary, 1 for secondary);
  - word 0 bits 30:7 equal the segment ID;
  - word 0 bits 5:0 equal page index bits 15:10.
- R5: On the first qualifying entry, the walker reads nothing more. It pulses `done` for one cycle with `out_rpn` = word 1 bits 31:12, `out_prot` = word 1 bits 1:0, and the request's segment ID and page index.
- R6: The secondary pass starts only after all eight primary entries miss. It uses the complemented hash to form the group address.
- R7: When both groups miss, the walker pulses `fault` for one cycle after exactly 32 word reads and does not pulse `done`.
- R8: `req_ready` is low from acceptance until the cycle of the `done` or `fault` pulse. Requests offered while it is low have no effect on the walk.
- R9: While `rd_valid` is high and `rd_ready` is low, `rd_valid` stays high and `rd_addr` stays stable.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Walk request offered |
| req_ready | output | 1 | Walker idle and accepting |
| req_vsid | input | 24 | Virtual segment ID |
| req_page | input | 16 | Page index |
| req_sdr | input | 32 | Storage-description register value |
| rd_valid | output | 1 | Memory read request |
| rd_ready | input | 1 | Memory accepts the read |
| rd_addr | output | 32 | Byte address of the 32-bit word |
| rd_rsp_valid | input | 1 | Read data returned |
| rd_rsp_data | input | 32 | Read data |
| done | output | 1 | One-cycle pulse: translation found |
| fault | output | 1 | One-cycle pulse: hash-table miss |
| out_rpn | output | 20 | Real page number |
| out_prot | output | 2 | Protection bits |
| out_vsid | output | 24 | Segment ID for the refill |
| out_page | output | 16 | Page index for the refill |

## Verification
The bench places decoy entries ahead of the real one. These are an invalid entry, an entry whose abbreviated index is wrong, and an entry whose hash-select bit belongs to the other pass. A walker that skipped any one match condition would stop early and return the decoy's page number. The secondary-hit and double-miss walks check the address of the 17th read and the total read count. A walker that complemented the wrong value, or that failed to restart the entry index, would read the wrong group or stop at the wrong count. A walk with a zero mask field and a segment ID that sets all hash bits shows whether high hash bits leak into the origin. A request offered during a busy walk would corrupt the returned fields if the walker accepted it.

// File: rtl/pte_walker.sv
module pte_walker #(
  parameter int ENTRIES = 8
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        req_valid,
  output logic        req_ready,
  input  logic [23:0] req_vsid,
  input  logic [15:0] req_page,
  input  logic [31:0] req_sdr,
  output logic        rd_valid,
  input  logic        rd_ready,
  output logic [31:0] rd_addr,
  input  logic        rd_rsp_valid,
  input  logic [31:0] rd_rsp_data,
  output logic        done,
  output logic        fault,
  output logic [19:0] out_rpn,
  output logic [1:0]  out_prot,
  output logic [23:0] out_vsid,
  output logic [15:0] out_page
);
  localparam int IDX_W   = $clog2(ENTRIES);
  localparam int GRP_SH  = IDX_W + 3;
  localparam int HASH_W  = 19;
  localparam logic [31:0] FIXED_MASK = (32'h1 << 16) - (32'h1 << GRP_SH);

  typedef enum logic [1:0] {S_IDLE, S_ISSUE, S_WAIT} state_t;
  state_t state;

  logic [23:0]       vsid_q;
  logic [15:0]       page_q;
  logic [31:0]       sdr_q;
  logic [HASH_W-1:0] hash_q;
  logic              pass_q;
  logic [IDX_W-1:0]  idx_q;
  logic              half_q;
  logic [31:0]       w0_q;

  wire [HASH_W-1:0] hash_in = req_vsid[HASH_W-1:0] ^ {{(HASH_W-16){1'b0}}, req_page};
  wire [31:0] origin = {sdr_q[31:16], 16'h0};
  wire [31:0] mask   = (32'(sdr_q[8:0]) << 16) | FIXED_MASK;
  wire [31:0] group  = origin | ((32'(hash_q) << GRP_SH) & mask);

  wire hit = w0_q[31] && (w0_q[6] == pass_q) && (w0_q[30:7] == vsid_q)
             && (w0_q[5:0] == page_q[15:10]);
  wire last_idx = (idx_q == IDX_W'(ENTRIES - 1));

  assign req_ready = (state == S_IDLE);
  assign rd_valid  = (state == S_ISSUE);
  assign rd_addr   = group | 32'({idx_q, half_q, 2'b00});

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state  <= S_IDLE;
      done   <= 1'b0;
      fault  <= 1'b0;
      pass_q <= 1'b0;
      idx_q  <= '0;
      half_q <= 1'b0;
      vsid_q <= '0;
      page_q <= '0;
      sdr_q  <= '0;
      hash_q <= '0;
      w0_q   <= '0;
      out_rpn  <= '0;
      out_prot <= '0;
      out_vsid <= '0;
      out_page <= '0;
    end else begin
      done  <= 1'b0;
      fault <= 1'b0;
      case (state)
        S_IDLE: if (req_valid) begin
          vsid_q <= req_vsid;
          page_q <= req_page;
          sdr_q  <= req_sdr;
          hash_q <= hash_in;
          pass_q <= 1'b0;
          idx_q  <= '0;
          half_q <= 1'b0;
          state  <= S_ISSUE;
        end
        S_ISSUE: if (rd_ready) state <= S_WAIT;
        S_WAIT: if (rd_rsp_valid) begin
          if (!half_q) begin
            w0_q   <= rd_rsp_data;
            half_q <= 1'b1;
            state  <= S_ISSUE;
          end else if (hit) begin
            out_rpn  <= rd_rsp_data[31:12];
            out_prot <= rd_rsp_data[1:0];
            out_vsid <= vsid_q;
            out_page <= page_q;
            done     <= 1'b1;
            state    <= S_IDLE;
          end else if (!last_idx) begin
            idx_q  <= idx_q + 1'b1;
            half_q <= 1'b0;
            state  <= S_ISSUE;
          end else if (!pass_q) begin
            pass_q <= 1'b1;
            hash_q <= ~hash_q;
            idx_q  <= '0;
            half_q <= 1'b0;
            state  <= S_ISSUE;
          end else begin
            fault <= 1'b1;
            state <= S_IDLE;
          end
        end
        default: state <= S_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/pte_walker_chk.sv
module pte_walker_chk (
  input logic        clk,
  input logic        rst_n,
  input logic        req_ready,
  input logic        rd_valid,
  input logic        rd_ready,
  input logic [31:0] rd_addr,
  input logic        done,
  input logic        fault
);
  assert_done_fault_excl_R7: assert property (@(posedge clk) disable iff (!rst_n)
    !(done && fault));
  assert_read_hold_R9: assert property (@(posedge clk) disable iff (!rst_n)
    rd_valid && !rd_ready |=> rd_valid && $stable(rd_addr));
  assert_idle_no_read_R8: assert property (@(posedge clk) disable iff (!rst_n)
    req_ready |-> !rd_valid);
  assert_end_frees_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (done || fault) |-> req_ready);
  assert_word_aligned_R3: assert property (@(posedge clk) disable iff (!rst_n)
    rd_valid |-> rd_addr[1:0] == 2'b00);
  assert_pulse_R5: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);
endmodule

bind pte_walker pte_walker_chk u_chk (
  .clk(clk), .rst_n(rst_n), .req_ready(req_ready), .rd_valid(rd_valid),
  .rd_ready(rd_ready), .rd_addr(rd_addr), .done(done), .fault(fault)
);

// File: tb/tb_pte_walker.sv
module tb_pte_walker;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic req_valid = 1'b0;
  logic req_ready;
  logic [23:0] req_vsid = '0;
  logic [15:0] req_page = '0;
  logic [31:0] req_sdr = '0;
  logic rd_valid, rd_ready = 1'b0;
  logic [31:0] rd_addr;
  logic rd_rsp_valid = 1'b0;
  logic [31:0] rd_rsp_data = '0;
  logic done, fault;
  logic [19:0] out_rpn;
  logic [1:0] out_prot;
  logic [23:0] out_vsid;
  logic [15:0] out_page;

  pte_walker dut (.*);

  always #10 clk = ~clk;

  int checks = 0, fails = 0, cyc = 0;
  logic [31:0] mem [logic [31:0]];
  logic [31:0] addr_log [0:63];
  int nreads = 0;
  bit pend = 0; logic [31:0] paddr; int delay = 0, lat = 0;
  bit got_done = 0, got_fault = 0;
  logic [19:0] c_rpn; logic [1:0] c_prot; logic [23:0] c_vsid; logic [15:0] c_page;

  always @(posedge clk) begin
    cyc <= cyc + 1;
    if (rd_valid && rd_ready) begin
      if (nreads < 64) addr_log[nreads] = rd_addr;
      nreads = nreads + 1;
      pend = 1; paddr = rd_addr; delay = lat;
    end
    if (done) begin
      got_done = 1; c_rpn = out_rpn; c_prot = out_prot; c_vsid = out_vsid; c_page = out_page;
    end
    if (fault) got_fault = 1;
  end

  always @(negedge clk) begin
    rd_ready <= (cyc % 3) != 1;
    if (pend && delay == 0) begin
      rd_rsp_valid <= 1'b1;
      rd_rsp_data  <= mem.exists(paddr) ? mem[paddr] : 32'h0;
      pend = 0;
    end else begin
      rd_rsp_valid <= 1'b0;
      if (pend) delay = delay - 1;
    end
  end

  task automatic check(input string req, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  function automatic logic [31:0] grp(input logic [23:0] v, input logic [15:0] p,
                                       input logic [31:0] s, input bit sec);
    logic [18:0] h = v[18:0] ^ {3'b0, p};
    logic [31:0] m = {7'b0, s[8:0], 10'h3FF, 6'b0};
    if (sec) h = ~h;
    return {s[31:16], 16'h0} | ({13'b0, h, 6'b0} & m);
  endfunction

  function automatic logic [31:0] pw0(input bit v, input logic [23:0] id, input bit h,
                                       input logic [5:0] api);
    return {v, id, h, api};
  endfunction

  function automatic logic [31:0] pw1(input logic [19:0] rpn, input logic [1:0] pp);
    return {rpn, 10'h0, pp};
  endfunction

  task automatic put(input logic [31:0] a, input logic [31:0] w0, input logic [31:0] w1);
    mem[a] = w0; mem[a + 4] = w1;
  endtask

  task automatic walk(input logic [23:0] v, input logic [15:0] p, input logic [31:0] s);
    nreads = 0; got_done = 0; got_fault = 0;
    @(negedge clk);
    req_vsid = v; req_page = p; req_sdr = s; req_valid = 1'b1;
    while (!req_ready) @(negedge clk);
    @(negedge clk);
    req_valid = 1'b0;
  endtask

  task automatic finish_walk();
    for (int i = 0; i < 3000 && !got_done && !got_fault; i++) @(negedge clk);
    repeat (3) @(negedge clk);
  endtask

  localparam logic [31:0] SDR = 32'h7E00_01FF;

  task automatic t_reset();
    check("R1 done", done, 0);
    check("R1 fault", fault, 0);
    check("R1 rd_valid", rd_valid, 0);
    check("R1 req_ready", req_ready, 1);
  endtask

  task automatic t_primary_first();
    mem.delete(); lat = 0;
    put(grp(24'h00ABCD, 16'h1234, SDR, 0), pw0(1, 24'h00ABCD, 0, 6'h04), pw1(20'hABCDE, 2'd2));
    walk(24'h00ABCD, 16'h1234, SDR); finish_walk();
    check("R2 group address", addr_log[0], grp(24'h00ABCD, 16'h1234, SDR, 0));
    check("R2 group constant", addr_log[0], 32'h7E2E_7E40);
    check("R3 word1 address", addr_log[1], addr_log[0] + 4);
    check("R5 done", got_done, 1);
    check("R5 rpn", c_rpn, 20'hABCDE);
    check("R5 prot", c_prot, 2'd2);
    check("R5 vsid", c_vsid, 24'h00ABCD);
    check("R5 page", c_page, 16'h1234);
    check("R5 stops reading", nreads, 2);
  endtask

  task automatic t_decoys();
    logic [31:0] g = grp(24'h123456, 16'hFC00, SDR, 0);
    mem.delete(); lat = 2;
    put(g + 8,  pw0(0, 24'h123456, 0, 6'h3F), pw1(20'h11111, 1));
    put(g + 16, pw0(1, 24'h123456, 0, 6'h3E), pw1(20'h22222, 1));
    put(g + 24, pw0(1, 24'h123456, 1, 6'h3F), pw1(20'h33333, 1));
    put(g + 32, pw0(1, 24'h123457, 0, 6'h3F), pw1(20'h44444, 1));
    put(g + 40, pw0(1, 24'h123456, 0, 6'h3F), pw1(20'h55555, 3));
    walk(24'h123456, 16'hFC00, SDR); finish_walk();
    check("R4 decoys skipped rpn", c_rpn, 20'h55555);
    check("R4 prot", c_prot, 2'd3);
    check("R3 read count", nreads, 12);
    for (int i = 0; i < 12; i++)
      check("R3 ascending", addr_log[i], g + 32'(4 * i));
  endtask

  task automatic t_secondary();
    logic [31:0] g0 = grp(24'h0F00F0, 16'h8421, SDR, 0);
    logic [31:0] g1 = grp(24'h0F00F0, 16'h8421, SDR, 1);
    mem.delete(); lat = 1;
    put(g0 + 8, pw0(1, 24'h0F00F0, 1, 6'h21), pw1(20'h99999, 0));
    put(g1 + 8, pw0(1, 24'h0F00F0, 0, 6'h21), pw1(20'h77777, 0));
    put(g1 + 24, pw0(1, 24'h0F00F0, 1, 6'h21), pw1(20'h6789A, 1));
    walk(24'h0F00F0, 16'h8421, SDR); finish_walk();
    check("R6 secondary group", addr_log[16], g1);
    check("R6 after full primary", addr_log[15], g0 + 60);
    check("R6 read count", nreads, 24);
    check("R6 rpn", c_rpn, 20'h6789A);
    check("R6 done", got_done, 1);
  endtask

  task automatic t_miss();
    mem.delete(); lat = 0;
    walk(24'h000001, 16'h0002, SDR); finish_walk();
    check("R7 fault", got_fault, 1);
    check("R7 no done", got_done, 0);
    check("R7 read count", nreads, 32);
    check("R7 ready after", req_ready, 1);
  endtask

  task automatic t_mask();
    logic [31:0] s = 32'h7E00_0000;
    mem.delete(); lat = 0;
    put(32'h7E00_FFC0, pw0(1, 24'h07FFFF, 0, 6'h00), pw1(20'h0BEEF, 1));
    walk(24'h07FFFF, 16'h0000, s); finish_walk();
    check("R2 masked group", addr_log[0], 32'h7E00_FFC0);
    check("R2 masked hit", c_rpn, 20'h0BEEF);
  endtask

  task automatic t_busy();
    logic [31:0] g = grp(24'h00AAAA, 16'h5555, SDR, 0);
    mem.delete(); lat = 3;
    put(g + 56, pw0(1, 24'h00AAAA, 0, 6'h15), pw1(20'hCAFE0, 2));
    put(grp(24'h00BBBB, 16'h4444, SDR, 0), pw0(1, 24'h00BBBB, 0, 6'h11), pw1(20'hDEAD0, 1));
    walk(24'h00AAAA, 16'h5555, SDR);
    repeat (2) @(negedge clk);
    check("R8 busy not ready", req_ready, 0);
    req_vsid = 24'h00BBBB; req_page = 16'h4444; req_valid = 1'b1;
    repeat (6) @(negedge clk);
    req_valid = 1'b0;
    finish_walk();
    check("R8 first request rpn", c_rpn, 20'hCAFE0);
    check("R8 first request vsid", c_vsid, 24'h00AAAA);
    check("R8 read count", nreads, 16);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    t_reset();
    rst_n = 1'b1;
    t_reset();
    t_primary_first();
    t_decoys();
    t_secondary();
    t_miss();
    t_mask();
    t_busy();
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  end

  initial begin
    wait (cyc > 100000);
    checks++; fails++;
    $display("FAIL watchdog: actual %0d expected <100000 cycles", cyc);
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  end
endmodule